// File: doc/BRIEF.md
# Incoherent Per-Processor View Memory

This block models shared memory for a small group of processors that do not see each other's writes automatically. It holds one global memory array and, for each processor, a private view of every address. A view entry carries a data value, a live flag (the view holds a value for that address) and a new flag (the value has not yet been copied back to global memory). Reads and writes from a processor touch only its own view, so they complete quickly. A processor sees data written elsewhere only after it runs an explicit barrier on that address.

Each processor has its own request port with a valid/ready handshake, carrying one of three operations: read, write or barrier. Inside the block, a scheduler starts three kinds of internal action whenever a pending request needs one and the action's guard holds. Copy-in loads global data into a view. Copy-out writes a view value back to global memory. Drop empties a view entry. Only one copy-out can write global memory per cycle, and a fixed-priority arbiter picks which one.

Top module: `ivm_top`

## Requirements
- R1: A read (op code 2'b00) completes only in a cycle where the requester's view entry is live, and returns that view value. A read of an entry that is not live waits exactly one cycle, during which a copy-in fills the entry.
- R2: A write (op code 2'b01) is accepted in the cycle it is presented. At the next edge it stores the data into the requester's view and makes the entry both live and new.
- R3: A copy-in loads the global value as it stood at the start of its cycle. A copy-out of the same address by another processor in that same cycle is not seen.
- R4: A copy-out fires only for an entry that is new. It writes the view value to global memory and clears the new flag.
- R5: A drop fires only for an entry that is live and not new, and it makes the entry not live.
- R6: A barrier (op code 2'b10) completes only when the requester's entry is not live. From a live, new entry it waits two cycles (copy-out, then drop). From a live entry that is not new it waits one cycle. From an entry that is not live it completes at once.
- R7: A read never observes another processor's write that has not yet been copied out and then fetched through a barrier. A stale live entry keeps returning its old value.
- R8: At most one global write happens per cycle. When several processors need a copy-out at once, the lowest processor index wins and each loser retries in the following cycle.
- R9: An entry whose new flag is set is always live.
- R10: After reset every view entry is empty and every global location holds zero.
- R11: Op code 2'b11 is reserved. It is accepted at once and changes no view or global state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NPROC | Request valid, one bit per processor |
| req_op | input | 2*NPROC | Operation code per processor (00 read, 01 write, 10 barrier, 11 reserved) |
| req_addr | input | AW*NPROC | Address per processor |
| req_wdata | input | DW*NPROC | Write data per processor |
| req_ready | output | NPROC | Request completes at the edge where valid and ready are both high |
| rsp_rdata | output | DW*NPROC | Read data per processor, valid while a read is ready |

## Verification
Two pairs of actions can fall in the same cycle. The first pair is copy-out requests from two processors on one address. The bench provokes this by forking barriers on two dirty views at the same edge. It then judges the result by the staggered barrier latencies (two and three cycles) and by a third processor reading the later writer's value. The second pair is one processor's copy-out coinciding with another's copy-in of the same address. The bench forks a barrier on a dirty entry against a read miss elsewhere, and expects the reader to get the old global value, then the new value after its own barrier.

// File: rtl/ivm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the incoherent view memory.
// Assumes the request op field is two bits wide.
package ivm_pkg;
    typedef enum logic [1:0] {
        OP_READ    = 2'b00,
        OP_WRITE   = 2'b01,
        OP_BARRIER = 2'b10,
        OP_NONE    = 2'b11
    } op_e;
endpackage

// File: rtl/ivm_arb.sv
`timescale 1ns/1ps
// Fixed-priority arbiter: the lowest requesting index is granted.
// Assumes requests are held until granted; grant is combinational.
module ivm_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // Pick the first requester from index 0 upward.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ivm_glob.sv
`timescale 1ns/1ps
// Global memory array: one read port per processor, one write port.
// Assumes the write port is driven by a single arbitrated winner.
module ivm_glob #(
    parameter int NPROC = 3,
    parameter int NADDR = 4,
    parameter int DW    = 8,
    localparam int AW   = (NADDR > 1) ? $clog2(NADDR) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPROC*AW-1:0] rd_addr,
    output logic [NPROC*DW-1:0] rd_data,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data
);
    logic [DW-1:0] mem_q [NADDR];

    // Clear on reset, otherwise apply the granted copy-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NADDR; a++) mem_q[a] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Each processor reads the value held at the start of the cycle.
    for (genvar p = 0; p < NPROC; p++) begin : g_rd
        assign rd_data[p*DW +: DW] = mem_q[rd_addr[p*AW +: AW]];
    end
endmodule

// File: rtl/ivm_view.sv
`timescale 1ns/1ps
// One processor's private view with its guards and demand scheduler.
// Assumes one request at a time on the port; a pending read triggers
// copy-in, a pending barrier triggers copy-out and then drop.
module ivm_view
    import ivm_pkg::*;
#(
    parameter int NADDR = 4,
    parameter int DW    = 8,
    localparam int AW   = (NADDR > 1) ? $clog2(NADDR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic [DW-1:0]    rsp_rdata,
    input  logic [DW-1:0]    glob_val,
    output logic             cout_req,
    input  logic             cout_grant,
    output logic [DW-1:0]    cout_data,
    output logic [NADDR-1:0] live_o,
    output logic [NADDR-1:0] new_o
);
    logic [DW-1:0]    val_q [NADDR];
    logic [NADDR-1:0] live_q, new_q;
    op_e              op;
    logic             ent_live, ent_new;
    logic             do_wr, do_in, do_drop;

    assign op = op_e'(req_op);

    // Guards and action selection for the addressed entry.
    always_comb begin
        ent_live  = live_q[req_addr];
        ent_new   = new_q[req_addr];
        req_ready = 1'b0;
        do_wr     = 1'b0;
        do_in     = 1'b0;
        cout_req  = 1'b0;
        do_drop   = 1'b0;
        case (op)
            OP_READ: begin
                req_ready = ent_live;
                do_in     = req_valid && !ent_live;
            end
            OP_WRITE: begin
                req_ready = 1'b1;
                do_wr     = req_valid;
            end
            OP_BARRIER: begin
                req_ready = !ent_live;
                cout_req  = req_valid && ent_live && ent_new;
                do_drop   = req_valid && ent_live && !ent_new;
            end
            default: req_ready = 1'b1;
        endcase
    end

    assign rsp_rdata = val_q[req_addr];
    assign cout_data = val_q[req_addr];
    assign live_o    = live_q;
    assign new_o     = new_q;

    // Update the entry for write, copy-in, granted copy-out or drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            new_q  <= '0;
            for (int a = 0; a < NADDR; a++) val_q[a] <= '0;
        end else begin
            if (do_wr) begin
                val_q[req_addr]  <= req_wdata;
                live_q[req_addr] <= 1'b1;
                new_q[req_addr]  <= 1'b1;
            end
            if (do_in) begin
                val_q[req_addr]  <= glob_val;
                live_q[req_addr] <= 1'b1;
            end
            if (cout_req && cout_grant) begin
                new_q[req_addr] <= 1'b0;
            end
            if (do_drop) begin
                live_q[req_addr] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ivm_top.sv
`timescale 1ns/1ps
// Incoherent view memory top: per-processor views, arbitrated
// copy-out into one global array. No cross-view coherence.
// Assumes each port holds its request until ready.
module ivm_top #(
    parameter int NPROC = 3,
    parameter int NADDR = 4,
    parameter int DW    = 8,
    localparam int AW   = (NADDR > 1) ? $clog2(NADDR) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPROC-1:0]    req_valid,
    input  logic [2*NPROC-1:0]  req_op,
    input  logic [AW*NPROC-1:0] req_addr,
    input  logic [DW*NPROC-1:0] req_wdata,
    output logic [NPROC-1:0]    req_ready,
    output logic [DW*NPROC-1:0] rsp_rdata
);
    logic [NPROC-1:0]       cout_req, cout_grant;
    logic [DW*NPROC-1:0]    cout_data_all, glob_rd;
    logic [NPROC*NADDR-1:0] live_all, new_all;
    logic                   gw_en;
    logic [AW-1:0]          gw_addr;
    logic [DW-1:0]          gw_data;

    for (genvar p = 0; p < NPROC; p++) begin : g_view
        ivm_view #(.NADDR(NADDR), .DW(DW)) view_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_valid  (req_valid[p]),
            .req_op     (req_op[2*p +: 2]),
            .req_addr   (req_addr[p*AW +: AW]),
            .req_wdata  (req_wdata[p*DW +: DW]),
            .req_ready  (req_ready[p]),
            .rsp_rdata  (rsp_rdata[p*DW +: DW]),
            .glob_val   (glob_rd[p*DW +: DW]),
            .cout_req   (cout_req[p]),
            .cout_grant (cout_grant[p]),
            .cout_data  (cout_data_all[p*DW +: DW]),
            .live_o     (live_all[p*NADDR +: NADDR]),
            .new_o      (new_all[p*NADDR +: NADDR])
        );
    end

    ivm_arb #(.N(NPROC)) arb_i (
        .req   (cout_req),
        .grant (cout_grant)
    );

    // Route the granted copy-out to the global write port.
    always_comb begin
        gw_en   = |cout_grant;
        gw_addr = '0;
        gw_data = '0;
        for (int p = 0; p < NPROC; p++) begin
            if (cout_grant[p]) begin
                gw_addr = req_addr[p*AW +: AW];
                gw_data = cout_data_all[p*DW +: DW];
            end
        end
    end

    ivm_glob #(.NPROC(NPROC), .NADDR(NADDR), .DW(DW)) glob_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (req_addr),
        .rd_data (glob_rd),
        .wr_en   (gw_en),
        .wr_addr (gw_addr),
        .wr_data (gw_data)
    );
endmodule

// File: rtl/ivm_chk.sv
`timescale 1ns/1ps
// Property checker for ivm_top, attached by bind below.
// Assumes the same parameters as the bound instance.
module ivm_chk #(
    parameter int NPROC = 3,
    parameter int NADDR = 4,
    localparam int AW   = (NADDR > 1) ? $clog2(NADDR) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPROC-1:0]       req_valid,
    input logic [2*NPROC-1:0]     req_op,
    input logic [AW*NPROC-1:0]    req_addr,
    input logic [NPROC-1:0]       req_ready,
    input logic [NPROC-1:0]       cout_req,
    input logic [NPROC-1:0]       cout_grant,
    input logic [NPROC*NADDR-1:0] live_all,
    input logic [NPROC*NADDR-1:0] new_all
);
    // R9: new implies live in every entry
    a_r9_new_implies_live: assert property (@(posedge clk) disable iff (!rst_n)
        (new_all & ~live_all) == '0);

    // R8: at most one global write per cycle
    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cout_grant));

    // R8: grant only goes to a requester
    a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (cout_grant & ~cout_req) == '0);

    for (genvar p = 0; p < NPROC; p++) begin : g_p
        logic          wr_q;
        logic [AW-1:0] wa_q;

        // Remember an accepted write for the next-cycle check.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_q <= 1'b0;
                wa_q <= '0;
            end else begin
                wr_q <= req_valid[p] && req_op[2*p +: 2] == 2'b01;
                wa_q <= req_addr[p*AW +: AW];
            end
        end

        // R2: a write is never stalled
        a_r2_write_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_op[2*p +: 2] == 2'b01) |-> req_ready[p]);

        // R2: the written entry is live and new afterwards
        a_r2_write_marks_entry: assert property (@(posedge clk) disable iff (!rst_n)
            wr_q |-> (new_all[p*NADDR + int'(wa_q)] && live_all[p*NADDR + int'(wa_q)]));

        // R1: a read completes only from a live entry
        a_r1_read_live: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_ready[p] && req_op[2*p +: 2] == 2'b00)
            |-> live_all[p*NADDR + int'(req_addr[p*AW +: AW])]);

        // R6: a barrier completes only on an entry that is not live
        a_r6_barrier_not_live: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_ready[p] && req_op[2*p +: 2] == 2'b10)
            |-> !live_all[p*NADDR + int'(req_addr[p*AW +: AW])]);
    end
endmodule

bind ivm_top ivm_chk #(.NPROC(NPROC), .NADDR(NADDR)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .cout_req   (cout_req),
    .cout_grant (cout_grant),
    .live_all   (live_all),
    .new_all    (new_all)
);

// File: tb/ivm_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected read data, a monitor
// pops and compares it when a read handshake completes.
module ivm_top_tb_top;
    localparam int NP = 3;
    localparam int NA = 4;
    localparam int DW = 8;
    localparam int AW = 2;
    localparam logic [1:0] RD = 2'b00, WR = 2'b01, BAR = 2'b10, RSV = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    valid = '0;
    logic [2*NP-1:0]  op    = '0;
    logic [AW*NP-1:0] addr  = '0;
    logic [DW*NP-1:0] wdata = '0;
    logic [NP-1:0]    ready;
    logic [DW*NP-1:0] rdata;

    always #2.5 clk = ~clk;

    ivm_top #(.NPROC(NP), .NADDR(NA), .DW(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (valid),
        .req_op    (op),
        .req_addr  (addr),
        .req_wdata (wdata),
        .req_ready (ready),
        .rsp_rdata (rdata)
    );

    typedef struct {
        int            p;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;
    exp_t sb[$];

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // Count one check and report a mismatch.
    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Present one request, wait for the handshake, report waiting cycles.
    task automatic issue(input int p, input logic [1:0] o, input int a,
                         input logic [DW-1:0] d, input logic [DW-1:0] exp_rd,
                         input string tag, output int lat);
        @(negedge clk);
        valid[p]            = 1'b1;
        op[2*p +: 2]        = o;
        addr[p*AW +: AW]    = a[AW-1:0];
        wdata[p*DW +: DW]   = d;
        if (o == RD) sb.push_back('{p: p, d: exp_rd, tag: tag});
        lat = 0;
        forever begin
            #1;
            if (ready[p]) break;
            lat++;
            @(negedge clk);
        end
        @(negedge clk);
        valid[p] = 1'b0;
    endtask

    // Monitor: compare each completing read against the scoreboard.
    always begin
        @(negedge clk);
        #1;
        for (int p = 0; p < NP; p++) begin
            if (rst_n && valid[p] && ready[p] && op[2*p +: 2] == RD) begin
                int idx;
                idx = -1;
                for (int i = 0; i < sb.size(); i++)
                    if (idx < 0 && sb[i].p == p) idx = i;
                if (idx < 0) begin
                    check(1'b0, "R1", "unexpected read", p, -1);
                end else begin
                    check(rdata[p*DW +: DW] === sb[idx].d, sb[idx].tag, "read data",
                          int'(rdata[p*DW +: DW]), int'(sb[idx].d));
                    sb.delete(idx);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            check(1'b0, "WATCHDOG", "timeout", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int l0, l1, l2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: empty views, barrier completes at once; global reads zero
        issue(0, BAR, 0, 8'h00, 8'h00, "R10", l0);
        check(l0 == 0, "R10", "barrier wait after reset", l0, 0);
        issue(0, RD, 1, 8'h00, 8'h00, "R10", l0);
        // R1: miss waits one cycle for copy-in
        check(l0 == 1, "R1", "read miss wait", l0, 1);

        // R2: write accepted at once, then read hits with no wait
        issue(0, WR, 1, 8'h5A, 8'h00, "R2", l0);
        check(l0 == 0, "R2", "write wait", l0, 0);
        issue(0, RD, 1, 8'h00, 8'h5A, "R2", l0);
        check(l0 == 0, "R1", "read hit wait", l0, 0);

        // R7: another processor still sees global zero
        issue(1, RD, 1, 8'h00, 8'h00, "R7", l1);
        check(l1 == 1, "R7", "other view miss wait", l1, 1);

        // R6 R4: barrier on live+new entry waits copy-out then drop
        issue(0, BAR, 1, 8'h00, 8'h00, "R6", l0);
        check(l0 == 2, "R6", "barrier on dirty entry", l0, 2);

        // R7: stale live entry keeps its old value
        issue(1, RD, 1, 8'h00, 8'h00, "R7", l1);
        check(l1 == 0, "R7", "stale hit wait", l1, 0);
        // R5: drop of a clean live entry takes one cycle
        issue(1, BAR, 1, 8'h00, 8'h00, "R5", l1);
        check(l1 == 1, "R5", "barrier on clean entry", l1, 1);
        // R4: copied-out value now visible after refetch
        issue(1, RD, 1, 8'h00, 8'h5A, "R4", l1);
        check(l1 == 1, "R4", "refetch wait", l1, 1);

        // R2: last write wins inside one view
        issue(2, WR, 0, 8'h31, 8'h00, "R2", l2);
        issue(2, WR, 0, 8'h32, 8'h00, "R2", l2);
        issue(2, RD, 0, 8'h00, 8'h32, "R2", l2);
        issue(2, BAR, 0, 8'h00, 8'h00, "R6", l2);
        check(l2 == 2, "R6", "barrier after rewrite", l2, 2);
        issue(0, RD, 0, 8'h00, 8'h32, "R4", l0);

        // R8: simultaneous copy-outs, lowest index first
        issue(0, WR, 2, 8'h11, 8'h00, "R8", l0);
        issue(2, WR, 2, 8'h22, 8'h00, "R8", l2);
        fork
            issue(0, BAR, 2, 8'h00, 8'h00, "R8", l0);
            issue(2, BAR, 2, 8'h00, 8'h00, "R8", l2);
        join
        check(l0 == 2, "R8", "winner barrier wait", l0, 2);
        check(l2 == 3, "R8", "loser barrier wait", l2, 3);
        issue(1, RD, 2, 8'h00, 8'h22, "R8", l1);

        // R3: copy-in in the same cycle as a copy-out sees the old value
        issue(0, WR, 3, 8'h77, 8'h00, "R3", l0);
        fork
            issue(0, BAR, 3, 8'h00, 8'h00, "R3", l0);
            issue(1, RD, 3, 8'h00, 8'h00, "R3", l1);
        join
        check(l0 == 2, "R3", "barrier wait", l0, 2);
        check(l1 == 1, "R3", "concurrent miss wait", l1, 1);
        issue(1, BAR, 3, 8'h00, 8'h00, "R3", l1);
        issue(1, RD, 3, 8'h00, 8'h77, "R3", l1);

        // R11: reserved op completes at once and fills nothing
        issue(2, RSV, 3, 8'hEE, 8'h00, "R11", l2);
        check(l2 == 0, "R11", "reserved op wait", l2, 0);
        issue(2, RD, 3, 8'h00, 8'h77, "R11", l2);
        check(l2 == 1, "R11", "entry still empty", l2, 1);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1", "reads left unanswered", sb.size(), 0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule